// File: doc/BRIEF.md
# Single-Precision Float to Integer Converter

This block turns one IEEE-754 single-precision operand into a 32-bit integer, either two's-complement signed or unsigned. Rounding follows a two-bit mode taken from the floating-point control register. A per-operation truncate select overrides that mode and forces round toward zero, so the common truncating conversion does not need the control register to be rewritten.

A conversion is started by a one-cycle strobe. The integer and two exception flags, invalid and inexact, appear in registers one cycle later and stay there until the next strobe. Results that cannot be represented do not wrap: they clamp to fixed default integers and raise invalid. A flush-to-zero enable makes subnormal operands count as +0.

Top module: `flt2int_conv`

## Requirements
- R1: Mode code 00 rounds to nearest with ties to the even integer, 01 rounds toward +infinity, 10 toward -infinity and 11 toward zero.
- R2: When `in_trunc` is 1 the conversion rounds toward zero, whatever `in_rmode` holds.
- R3: A finite operand whose rounded value is above the destination maximum returns that maximum with invalid set. The maximum is 0x7FFFFFFF for signed and 0xFFFFFFFF for unsigned.
- R4: A finite operand whose rounded value is below the signed minimum returns 0x80000000 with invalid set.
- R5: +infinity returns the destination maximum and -infinity returns the destination minimum, with invalid set. The unsigned minimum is 0.
- R6: A NaN operand, quiet or signalling, returns 0 with invalid set.
- R7: Inexact is set exactly when an in-range operand is not an integer. Invalid and inexact are never both set, and an exactly representable integer raises no flag.
- R8: With `in_ftz` at 1, an operand with a zero exponent field returns 0 with no flag. With `in_ftz` at 0, a subnormal is a tiny nonzero value, so it rounds to 0 or ±1 and sets inexact.
- R9: For unsigned output, a negative operand that rounds to 0 returns 0 and sets only inexact, and only if it was inexact. A negative operand that rounds to -1 or below returns 0 with invalid set.
- R10: `out_valid` pulses exactly one cycle after each `in_valid`. The result and flags change only on that cycle and otherwise hold.
- R11: While reset is asserted, `out_valid`, `out_int` and both flags are 0.
- R12: Signed and unsigned in-range operands convert to the exact rounded integer. This includes the signed boundary -2^31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Conversion strobe |
| in_op | input | 32 | Single-precision operand |
| in_signed | input | 1 | 1 = signed destination, 0 = unsigned |
| in_trunc | input | 1 | 1 = force round toward zero |
| in_rmode | input | 2 | Rounding mode code (see R1) |
| in_ftz | input | 1 | Flush subnormal operands to +0 |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_int | output | 32 | Integer result |
| out_invalid | output | 1 | Invalid operation flag |
| out_inexact | output | 1 | Inexact flag |

## Verification
The block has a single register stage, so any internal fault appears in the same output cycle as the operation that exposes it. A misaligned significand shift shows up as a result that is off by a power of two. A wrong guard or sticky bit, or a wrong mode decode, shows up as a result off by one together with a wrong inexact flag. A wrong range compare shows up only at the exact boundary operands, as a missing or spurious saturation with invalid. For that reason the stimulus pairs directed boundary and tie operands with an exponent sweep and pseudo-random operands across every mode, and it compares each strobe's outputs against an arithmetic model.

// File: rtl/fti_pkg.sv
package fti_pkg;

   typedef enum logic [1:0] {
      RM_NEAREST = 2'b00,
      RM_UP      = 2'b01,
      RM_DOWN    = 2'b10,
      RM_ZERO    = 2'b11
   } fti_rmode_e;

   typedef struct packed {
      logic is_nan;
      logic is_inf;
      logic is_zero;
      logic sign;
   } fti_class_t;

endpackage

// File: rtl/fti_unpack.sv
module fti_unpack
   import fti_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   localparam int FP_W = 1 + EXP_W + MAN_W,
   localparam int E_W  = EXP_W + 2
) (
   input  logic [FP_W-1:0]         op,
   input  logic                    ftz,
   output fti_class_t              cls,
   output logic signed [E_W-1:0]   exp_unb,
   output logic [MAN_W:0]          sig
);
   localparam int BIAS = (1 << (EXP_W - 1)) - 1;
   localparam logic signed [E_W-1:0] BIAS_S = E_W'(BIAS);
   localparam logic signed [E_W-1:0] ONE_S  = E_W'(1);

   logic [EXP_W-1:0] exp_field;
   logic [MAN_W-1:0] man_field;
   logic             exp_ones;
   logic             exp_none;
   logic             man_any;

   assign exp_field = op[MAN_W +: EXP_W];
   assign man_field = op[MAN_W-1:0];
   assign exp_ones  = &exp_field;
   assign exp_none  = ~|exp_field;
   assign man_any   = |man_field;

   always_comb begin
      cls.sign    = op[FP_W-1];
      cls.is_nan  = exp_ones & man_any;
      cls.is_inf  = exp_ones & ~man_any;
      cls.is_zero = exp_none & (~man_any | ftz);
   end

   assign sig     = {~exp_none, man_field};
   assign exp_unb = exp_none ? (ONE_S - BIAS_S)
                             : ($signed({2'b00, exp_field}) - BIAS_S);

endmodule

// File: rtl/fti_align.sv
module fti_align #(
   parameter int MAN_W = 23,
   parameter int INT_W = 32,
   parameter int E_W   = 10,
   localparam int FB   = MAN_W + 2,
   localparam int FX_W = MAN_W + 1 + INT_W + 2
) (
   input  logic [MAN_W:0]         sig,
   input  logic signed [E_W-1:0]  exp_unb,
   output logic [INT_W:0]         int_mag,
   output logic                   guard,
   output logic                   sticky,
   output logic                   huge
);
   localparam logic signed [E_W-1:0] LIM_HI = E_W'(INT_W);
   localparam logic signed [E_W-1:0] LIM_LO = E_W'(-2);

   generate
      if (INT_W >= (1 << (E_W - 2))) begin : g_bad_range
         $error("fti_align: exponent width too small for INT_W");
      end
   endgenerate

   logic [FX_W-1:0] fx;
   logic [E_W-1:0]  sh;
   logic            tiny;

   assign sh   = exp_unb - LIM_LO;
   assign tiny = exp_unb < LIM_LO;
   assign huge = exp_unb > LIM_HI;

   always_comb begin
      if (huge || tiny) fx = '0;
      else              fx = FX_W'(sig) << sh;
   end

   always_comb begin
      int_mag = fx[FX_W-1:FB];
      if (tiny) begin
         guard  = 1'b0;
         sticky = |sig;
      end else begin
         guard  = fx[FB-1];
         sticky = |fx[FB-2:0];
      end
   end

endmodule

// File: rtl/fti_round.sv
module fti_round
   import fti_pkg::*;
#(
   parameter int INT_W = 32
) (
   input  logic [INT_W:0]    int_mag,
   input  logic              guard,
   input  logic              sticky,
   input  logic              sign,
   input  fti_rmode_e        mode,
   output logic [INT_W+1:0]  rnd_mag,
   output logic              inexact
);
   logic inc;

   assign inexact = guard | sticky;

   always_comb begin
      unique case (mode)
         RM_NEAREST: inc = guard & (sticky | int_mag[0]);
         RM_UP:      inc = ~sign & inexact;
         RM_DOWN:    inc = sign & inexact;
         default:    inc = 1'b0;
      endcase
   end

   assign rnd_mag = {1'b0, int_mag} + {{(INT_W+1){1'b0}}, inc};

endmodule

// File: rtl/fti_saturate.sv
module fti_saturate
   import fti_pkg::*;
#(
   parameter int INT_W = 32
) (
   input  fti_class_t          cls,
   input  logic                huge,
   input  logic [INT_W+1:0]    rnd_mag,
   input  logic                inexact_raw,
   input  logic                is_signed,
   output logic [INT_W-1:0]    result,
   output logic                invalid,
   output logic                inexact
);
   localparam logic [INT_W-1:0] SMAX = {1'b0, {(INT_W-1){1'b1}}};
   localparam logic [INT_W-1:0] SMIN = {1'b1, {(INT_W-1){1'b0}}};
   localparam logic [INT_W-1:0] UMAX = {INT_W{1'b1}};
   localparam logic [INT_W+1:0] SMAX_X = {2'b00, SMAX};
   localparam logic [INT_W+1:0] SMIN_X = {2'b00, SMIN};
   localparam logic [INT_W+1:0] UMAX_X = {2'b00, UMAX};

   logic big;
   assign big = huge | cls.is_inf;

   always_comb begin
      result  = '0;
      invalid = 1'b0;
      inexact = 1'b0;
      if (cls.is_nan) begin
         invalid = 1'b1;
      end else if (cls.is_zero) begin
         result = '0;
      end else if (is_signed) begin
         if (!cls.sign) begin
            if (big || rnd_mag > SMAX_X) begin
               result  = SMAX;
               invalid = 1'b1;
            end else begin
               result  = rnd_mag[INT_W-1:0];
               inexact = inexact_raw;
            end
         end else begin
            if (big || rnd_mag > SMIN_X) begin
               result  = SMIN;
               invalid = 1'b1;
            end else begin
               result  = -rnd_mag[INT_W-1:0];
               inexact = inexact_raw;
            end
         end
      end else begin
         if (!cls.sign) begin
            if (big || rnd_mag > UMAX_X) begin
               result  = UMAX;
               invalid = 1'b1;
            end else begin
               result  = rnd_mag[INT_W-1:0];
               inexact = inexact_raw;
            end
         end else begin
            if (big || rnd_mag != '0) begin
               invalid = 1'b1;
            end else begin
               inexact = inexact_raw;
            end
         end
      end
   end

endmodule

// File: rtl/flt2int_conv.sv
module flt2int_conv
   import fti_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23,
   parameter int INT_W = 32,
   localparam int FP_W = 1 + EXP_W + MAN_W,
   localparam int E_W  = EXP_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [FP_W-1:0]   in_op,
   input  logic              in_signed,
   input  logic              in_trunc,
   input  logic [1:0]        in_rmode,
   input  logic              in_ftz,
   output logic              out_valid,
   output logic [INT_W-1:0]  out_int,
   output logic              out_invalid,
   output logic              out_inexact
);
   generate
      if (EXP_W < 2 || MAN_W < 1 || INT_W < 2) begin : g_bad_params
         $error("flt2int_conv: unsupported parameter set");
      end
   endgenerate

   localparam logic [INT_W-1:0] SMAX = {1'b0, {(INT_W-1){1'b1}}};
   localparam logic [INT_W-1:0] SMIN = {1'b1, {(INT_W-1){1'b0}}};

   fti_class_t              cls;
   logic signed [E_W-1:0]   exp_unb;
   logic [MAN_W:0]          sig;
   logic [INT_W:0]          int_mag;
   logic                    guard, sticky, huge;
   logic [INT_W+1:0]        rnd_mag;
   logic                    inx_raw;
   fti_rmode_e              eff_mode;
   logic [INT_W-1:0]        sat_res;
   logic                    sat_inv, sat_inx;

   assign eff_mode = in_trunc ? RM_ZERO : fti_rmode_e'(in_rmode);

   fti_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_unpack (
      .op(in_op), .ftz(in_ftz), .cls(cls), .exp_unb(exp_unb), .sig(sig)
   );

   fti_align #(.MAN_W(MAN_W), .INT_W(INT_W), .E_W(E_W)) u_align (
      .sig(sig), .exp_unb(exp_unb), .int_mag(int_mag),
      .guard(guard), .sticky(sticky), .huge(huge)
   );

   fti_round #(.INT_W(INT_W)) u_round (
      .int_mag(int_mag), .guard(guard), .sticky(sticky), .sign(cls.sign),
      .mode(eff_mode), .rnd_mag(rnd_mag), .inexact(inx_raw)
   );

   fti_saturate #(.INT_W(INT_W)) u_sat (
      .cls(cls), .huge(huge), .rnd_mag(rnd_mag), .inexact_raw(inx_raw),
      .is_signed(in_signed), .result(sat_res), .invalid(sat_inv),
      .inexact(sat_inx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         out_int     <= '0;
         out_invalid <= 1'b0;
         out_inexact <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_int     <= sat_res;
            out_invalid <= sat_inv;
            out_inexact <= sat_inx;
         end
      end
   end

   // Operand field decodes used only by the properties below.
   logic op_exp_ones, op_exp_none, op_man_any, op_neg;
   assign op_exp_ones = &in_op[MAN_W +: EXP_W];
   assign op_exp_none = ~|in_op[MAN_W +: EXP_W];
   assign op_man_any  = |in_op[MAN_W-1:0];
   assign op_neg      = in_op[FP_W-1];

   p_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid && $stable(out_int) && $stable(out_invalid)
                    && $stable(out_inexact));
   p_flag_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !(out_invalid && out_inexact));
   p_nan_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && op_exp_ones && op_man_any
      |=> out_int == '0 && out_invalid && !out_inexact);
   p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ftz && op_exp_none
      |=> out_int == '0 && !out_invalid && !out_inexact);
   p_pinf_r5: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_signed && op_exp_ones && !op_man_any && !op_neg
      |=> out_int == SMAX && out_invalid);
   p_ninf_r5: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_signed && op_exp_ones && !op_man_any && op_neg
      |=> out_int == SMIN && out_invalid);
   p_uns_neg_r9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !in_signed && op_neg |=> out_int == '0);

endmodule

// File: tb/flt2int_conv_test.sv
`timescale 1ns/1ps
module flt2int_conv_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_op = '0;
   logic        in_signed = 1'b0;
   logic        in_trunc = 1'b0;
   logic [1:0]  in_rmode = 2'b00;
   logic        in_ftz = 1'b0;
   logic        out_valid;
   logic [31:0] out_int;
   logic        out_invalid;
   logic        out_inexact;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   bit vld_hist = 1'b0;

   always #2.5 clk = ~clk;

   flt2int_conv uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
      .in_signed(in_signed), .in_trunc(in_trunc), .in_rmode(in_rmode),
      .in_ftz(in_ftz), .out_valid(out_valid), .out_int(out_int),
      .out_invalid(out_invalid), .out_inexact(out_inexact)
   );

   task automatic chk(input string req, input logic [31:0] got,
                      input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h exp %h", req, got, exp);
      end
   endtask

   // R10: every clock, out_valid follows the previous cycle's strobe
   always @(posedge clk) vld_hist <= rst_n ? in_valid : 1'b0;
   always @(negedge clk) if (rst_n && !done) chk("R10 valid", 32'(out_valid), 32'(vld_hist));

   function automatic real rnd_even(input real x);
      real fl, fr, h;
      fl = $floor(x);
      fr = x - fl;
      h  = fl / 2.0;
      if (fr > 0.5) return fl + 1.0;
      if (fr < 0.5) return fl;
      return (h != $floor(h)) ? fl + 1.0 : fl;
   endfunction

   task automatic model(input logic [31:0] op, input bit sgn, input bit trc,
                        input logic [1:0] rm, input bit ftz,
                        output logic [31:0] r, output bit inv, output bit inx);
      int e;
      int p;
      real mag, x, rr;
      logic [1:0] m;
      longint li;
      bit neg;
      e   = int'(op[30:23]);
      neg = op[31];
      r = '0; inv = 0; inx = 0;
      if (e == 255) begin
         inv = 1;
         if (op[22:0] != 0)      r = 32'h0;
         else if (sgn) r = neg ? 32'h8000_0000 : 32'h7FFF_FFFF;
         else          r = neg ? 32'h0 : 32'hFFFF_FFFF;
         return;
      end
      if (e == 0 && ftz) return;
      mag = (e == 0) ? real'(op[22:0]) : real'({1'b1, op[22:0]});
      p   = (e == 0) ? -149 : e - 150;
      for (int k = 0; k < p; k++) mag = mag * 2.0;
      for (int k = 0; k > p; k--) mag = mag / 2.0;
      x = neg ? -mag : mag;
      m = trc ? 2'b11 : rm;
      case (m)
         2'b00: rr = rnd_even(x);
         2'b01: rr = $ceil(x);
         2'b10: rr = $floor(x);
         default: rr = (x < 0.0) ? $ceil(x) : $floor(x);
      endcase
      inx = (rr != x);
      if (sgn) begin
         if (rr > 2147483647.0)       begin r = 32'h7FFF_FFFF; inv = 1; end
         else if (rr < -2147483648.0) begin r = 32'h8000_0000; inv = 1; end
         else begin li = longint'(rr); r = li[31:0]; end
      end else begin
         if (rr > 4294967295.0) begin r = 32'hFFFF_FFFF; inv = 1; end
         else if (rr < 0.0)     begin r = 32'h0; inv = 1; end
         else begin li = longint'(rr); r = li[31:0]; end
      end
      if (inv) inx = 0;
   endtask

   task automatic run(input logic [31:0] op, input bit sgn, input bit trc,
                      input logic [1:0] rm, input bit ftz, input string req);
      logic [31:0] er;
      bit ei, ex;
      model(op, sgn, trc, rm, ftz, er, ei, ex);
      @(negedge clk);
      in_valid = 1'b1; in_op = op; in_signed = sgn; in_trunc = trc;
      in_rmode = rm; in_ftz = ftz;
      @(negedge clk);
      in_valid = 1'b0;
      in_op = ~op; in_signed = ~sgn; in_rmode = ~rm;
      chk({req, " result"}, out_int, er);
      chk({req, " invalid"}, 32'(out_invalid), 32'(ei));
      chk({req, " inexact"}, 32'(out_inexact), 32'(ex));
   endtask

   logic [31:0] lfsr = 32'hACE1_2468;
   logic [31:0] held;

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 valid", 32'(out_valid), 32'h0);
      chk("R11 int", out_int, 32'h0);
      chk("R11 flags", {30'h0, out_invalid, out_inexact}, 32'h0);
      rst_n = 1'b1;

      // R1 rounding modes and ties to even
      run(32'h3FC0_0000, 1, 0, 2'b00, 0, "R1 1.5 RN");
      run(32'h4020_0000, 1, 0, 2'b00, 0, "R1 2.5 RN");
      run(32'hC020_0000, 1, 0, 2'b00, 0, "R1 -2.5 RN");
      run(32'h3F00_0000, 1, 0, 2'b00, 0, "R1 0.5 RN");
      run(32'h4020_0000, 1, 0, 2'b01, 0, "R1 2.5 RP");
      run(32'hC020_0000, 1, 0, 2'b10, 0, "R1 -2.5 RM");
      run(32'h402C_CCCD, 1, 0, 2'b11, 0, "R1 2.7 RZ");
      run(32'hC02C_CCCD, 1, 0, 2'b11, 0, "R1 -2.7 RZ");
      // R2 truncate override
      run(32'h402C_CCCD, 1, 1, 2'b00, 0, "R2 2.7 trunc");
      run(32'hC02C_CCCD, 1, 1, 2'b10, 0, "R2 -2.7 trunc");
      run(32'h402C_CCCD, 0, 1, 2'b01, 0, "R2 2.7 trunc uns");
      // R3 / R4 / R12 boundaries
      run(32'h4F00_0000, 1, 0, 2'b00, 0, "R3 2^31 signed");
      run(32'h4EFF_FFFF, 1, 0, 2'b00, 0, "R12 max exact signed");
      run(32'hCF00_0000, 1, 0, 2'b00, 0, "R12 -2^31 signed");
      run(32'hCF00_0001, 1, 0, 2'b00, 0, "R4 below min");
      run(32'h4F80_0000, 0, 0, 2'b00, 0, "R3 2^32 unsigned");
      run(32'h4F7F_FFFF, 0, 0, 2'b00, 0, "R12 max exact unsigned");
      run(32'h7F7F_FFFF, 1, 0, 2'b00, 0, "R3 huge signed");
      run(32'hFF7F_FFFF, 1, 0, 2'b00, 0, "R4 huge negative");
      // R5 infinities
      run(32'h7F80_0000, 1, 0, 2'b00, 0, "R5 +inf s");
      run(32'hFF80_0000, 1, 0, 2'b00, 0, "R5 -inf s");
      run(32'h7F80_0000, 0, 0, 2'b00, 0, "R5 +inf u");
      run(32'hFF80_0000, 0, 0, 2'b00, 0, "R5 -inf u");
      // R6 NaNs
      run(32'h7FC0_0000, 1, 0, 2'b00, 0, "R6 qnan");
      run(32'h7F80_0001, 0, 0, 2'b00, 0, "R6 snan");
      run(32'hFFC0_0000, 1, 1, 2'b11, 0, "R6 neg nan");
      // R7 exact values and zeros
      run(32'h4120_0000, 1, 0, 2'b00, 0, "R7 10.0");
      run(32'h0000_0000, 1, 0, 2'b00, 0, "R7 +0");
      run(32'h8000_0000, 0, 0, 2'b00, 0, "R7 -0 unsigned");
      // R8 flush to zero and subnormals
      run(32'h0000_0001, 1, 0, 2'b01, 1, "R8 denorm ftz");
      run(32'h8040_0000, 1, 0, 2'b10, 1, "R8 neg denorm ftz");
      run(32'h0000_0001, 1, 0, 2'b01, 0, "R8 denorm RP");
      run(32'h8000_0001, 1, 0, 2'b10, 0, "R8 neg denorm RM");
      run(32'h0000_0001, 1, 0, 2'b00, 0, "R8 denorm RN");
      // R9 unsigned negatives
      run(32'hBE99_999A, 0, 0, 2'b00, 0, "R9 -0.3 RN");
      run(32'hBF33_3333, 0, 0, 2'b11, 0, "R9 -0.7 RZ");
      run(32'hBF33_3333, 0, 0, 2'b00, 0, "R9 -0.7 RN");
      run(32'hBF80_0000, 0, 0, 2'b11, 0, "R9 -1.0");
      run(32'hBF00_0000, 0, 0, 2'b00, 0, "R9 -0.5 RN tie");

      // R10 hold while idle
      held = out_int;
      @(negedge clk);
      chk("R10 hold int", out_int, held);

      // Exponent sweep across all modes (R1 R3 R4 R12)
      for (int e = 110; e < 170; e++) begin
         for (int m = 0; m < 4; m++) begin
            run({1'b0, 8'(e), 23'h2A_AAAB}, 1, 0, 2'(m), 0, "R12 sweep+");
            run({1'b1, 8'(e), 23'h40_0000}, 1, 0, 2'(m), 0, "R1 sweep-");
            run({1'b0, 8'(e), 23'h7F_FFFF}, 0, 0, 2'(m), 0, "R3 sweep u");
         end
      end

      // Pseudo-random operands, modes and selects
      for (int i = 0; i < 600; i++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         run({lfsr[31], (lfsr[4] ? 8'(8'd118 + 8'(lfsr[30:26])) : lfsr[30:23]),
              lfsr[22:0]},
             lfsr[5], lfsr[6] & lfsr[7], lfsr[9:8], lfsr[10], "R7 random");
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog got %h exp %h", 32'h0, 32'h1);
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule